// File: doc/BRIEF.md
# SDRAM Bank-Tracking Device Model

This block is a clocked, synthesizable stand-in for one single-data-rate SDRAM device. It can sit on a memory controller's pins as the memory itself, or beside a real device as a protocol monitor. Every clock edge it samples a 3-bit command, a row/column/bank address and a 16-bit write word. Read words come back on a data output after a fixed latency.

Inside, a small tracker per bank holds that bank's state, a countdown timer and the row opened in it. One transfer engine runs single-word or burst accesses against an internal word array. Any command that is illegal in the current bank states changes no bank and no transfer. It only raises an error indication: a one-cycle pulse, a sticky bit and the code of the offending command.

The interface has no back-pressure. A command is taken on every edge, and the read stream is a valid-only stream: the consumer must take each word in the cycle it is shown. The address splits as follows:
- The top bank bits select the bank.
- The low row bits give the row on activate.
- The low column bits give the start column on read or write.
- Address bit 10 is the all-banks select on precharge and the auto-precharge request on read or write.

Row addresses are folded onto a smaller stored row field, so distinct rows may alias inside the array.

Top module: `sdram_bank_model`

## Requirements
- R1: After reset every bank is in the unknown state, read data shows the empty marker 16'hE7E7 with rdata_valid low, the error outputs are low, and every stored word reads back as 16'hFEFE.
- R2: Command codes are 000 set-mode, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst-stop, 111 no-op. Set-mode and refresh are legal only when all banks are idle. Refresh puts all banks into refreshing, and an activate becomes legal T_RC-1 cycles after the refresh.
- R3: Precharge with address bit 10 high targets all banks, otherwise only the addressed bank. A targeted active or unknown bank becomes idle T_RP-1 cycles later. Precharging a bank that is opening, precharging or refreshing is an error.
- R4: Activate is legal only on an idle bank. It latches the row, and the bank accepts read or write T_RCD-1 cycles later. Activate on any other state is an error.
- R5: Read or write is legal only on a bank that is active, reading or writing. Otherwise it is an error with no effect.
- R6: A read beat issued in cycle c shows its word on rdata with rdata_valid high in cycle c+3. In a cycle with no word, rdata is 16'hE7E7 and rdata_valid is low.
- R7: A write beat stores wdata of that same cycle at the bank, the bank's open row and the current column.
- R8: A burst lasts BURST_LEN beats, one per cycle. The column advances by one per beat and wraps within the column field.
- R9: With address bit 10 high at read or write, the bank starts precharging when the burst ends. Without it, the bank stays active.
- R10: A read or write issued during a burst truncates that burst at once and starts the new one in the same cycle.
- R11: Burst-stop ends the running burst with no further beat, and the bank follows its auto-precharge flag.
- R12: An illegal command raises err_pulse for exactly the next cycle and loads err_cmd with its code. err_sticky stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code sampled every edge |
| addr | input | BANK_BITS+ROW_BITS | Bank, row / column and bit-10 flag |
| wdata | input | 16 | Write word for the current beat |
| rdata | output | 16 | Read word, or 16'hE7E7 when none |
| rdata_valid | output | 1 | rdata carries a read word |
| err_pulse | output | 1 | One-cycle flag after an illegal command |
| err_sticky | output | 1 | Set by any illegal command until reset |
| err_cmd | output | 3 | Code of the last illegal command |

## Verification
A bank whose state or timer is wrong shows up on the error outputs one cycle after the next command to that bank. It either flags a legal command or lets an illegal one pass, so the timer windows are probed at the first cycle where a command must fail and the cycle where it must pass. A wrong column, row latch, truncation or auto-precharge decision appears as a wrong or missing word on rdata exactly three cycles after the read beat, or as an unexpected error on the next activate. Write-then-read patterns that cross the column wrap, stop early or are cut short expose these faults.

// File: rtl/sdram_model_pkg.sv
package sdram_model_pkg;

  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] EMPTY_WORD = 16'hE7E7;
  localparam logic [WORD_W-1:0] FILL_WORD  = 16'hFEFE;

  typedef enum logic [2:0] {
    CMD_MODE      = 3'b000,
    CMD_REFRESH   = 3'b001,
    CMD_PRECHARGE = 3'b010,
    CMD_ACTIVATE  = 3'b011,
    CMD_WRITE     = 3'b100,
    CMD_READ      = 3'b101,
    CMD_STOP      = 3'b110,
    CMD_NOP       = 3'b111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    BK_UNKNOWN,
    BK_IDLE,
    BK_ACTIVE,
    BK_READING,
    BK_WRITING,
    BK_PRECHARGING,
    BK_REFRESHING,
    BK_OPENING
  } bank_state_e;

  // State a timed bank reaches when its countdown expires.
  function automatic bank_state_e settle(input bank_state_e s);
    case (s)
      BK_OPENING:                    return BK_ACTIVE;
      BK_PRECHARGING, BK_REFRESHING: return BK_IDLE;
      default:                       return s;
    endcase
  endfunction

endpackage

// File: rtl/sdram_word_store.sv
module sdram_word_store
  import sdram_model_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= FILL_WORD;
    end else if (we) begin
      mem_q[idx] <= wword;
    end
  end

  assign rword = mem_q[idx];

endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe
  import sdram_model_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);

  logic [DEPTH-1:0]  vld_q;
  logic [WORD_W-1:0] dat_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        vld_q[i] <= vld_q[i+1];
        dat_q[i] <= dat_q[i+1];
      end
      vld_q[DEPTH-1] <= in_valid;
      dat_q[DEPTH-1] <= in_valid ? in_word : '0;
    end
  end

  assign out_valid = vld_q[0];
  assign out_word  = vld_q[0] ? dat_q[0] : EMPTY_WORD;

  generate
    if (DEPTH > 1) begin : g_order_chk
      // R6: a word reaches the output only after passing the stage before it
      a_r6_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(vld_q[1]));
    end
  endgenerate

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_model_pkg::*;
#(
  parameter int ROW_BITS = 11,
  parameter int TMR_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  bank_state_e         upd_state,
  input  logic [TMR_W-1:0]    upd_busy,
  input  logic                row_load,
  input  logic [ROW_BITS-1:0] row_in,
  output bank_state_e         now_state,
  output logic [ROW_BITS-1:0] row_q
);

  bank_state_e      state_q;
  logic [TMR_W-1:0] busy_q;

  // A timer at 1 expires this cycle, so commands already see the settled state.
  assign now_state = (busy_q == TMR_W'(1)) ? settle(state_q) : state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BK_UNKNOWN;
      busy_q  <= '0;
    end else if (upd_en) begin
      state_q <= upd_state;
      busy_q  <= upd_busy;
    end else begin
      state_q <= now_state;
      if (busy_q != '0) busy_q <= busy_q - TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        row_q <= '0;
    else if (row_load) row_q <= row_in;
  end

  // R3: a countdown only runs in a state that waits on one
  a_r3_timer_in_wait_state: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q != '0) |-> (state_q inside {BK_PRECHARGING, BK_REFRESHING, BK_OPENING}));

  // R4: an opening bank whose timer expires untouched becomes active
  a_r4_opening_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BK_OPENING && busy_q == TMR_W'(1) && !upd_en) |=> (state_q == BK_ACTIVE));

endmodule

// File: rtl/sdram_bank_model.sv
module sdram_bank_model
  import sdram_model_pkg::*;
#(
  parameter int BANK_BITS = 1,
  parameter int ROW_BITS  = 11,
  parameter int COL_BITS  = 8,
  parameter int ROW_KEEP  = 2,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 1,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 8,
  parameter int RD_STAGES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    cmd,
  input  logic [BANK_BITS+ROW_BITS-1:0] addr,
  input  logic [15:0]                   wdata,
  output logic [15:0]                   rdata,
  output logic                          rdata_valid,
  output logic                          err_pulse,
  output logic                          err_sticky,
  output logic [2:0]                    err_cmd
);

  localparam int NBANK  = 1 << BANK_BITS;
  localparam int ADDR_W = BANK_BITS + ROW_BITS;
  localparam int IDX_W  = BANK_BITS + ROW_KEEP + COL_BITS;
  localparam int TMAX   = (T_RC > T_RCD) ? ((T_RC > T_RP) ? T_RC : T_RP)
                                         : ((T_RCD > T_RP) ? T_RCD : T_RP);
  localparam int TMR_W  = $clog2(TMAX + 1);
  localparam int CNT_W  = $clog2(BURST_LEN + 1);

  // Address fields
  sdr_cmd_e               cmd_e;
  logic [BANK_BITS-1:0]   tgt_bank;
  logic [ROW_BITS-1:0]    row_f;
  logic [COL_BITS-1:0]    col_f;
  logic                   flag10;

  assign cmd_e    = sdr_cmd_e'(cmd);
  assign tgt_bank = addr[ADDR_W-1 -: BANK_BITS];
  assign row_f    = addr[ROW_BITS-1:0];
  assign col_f    = addr[COL_BITS-1:0];
  assign flag10   = addr[AP_BIT];

  // Every row bit lands in the stored row field; rows beyond it alias.
  function automatic logic [ROW_KEEP-1:0] fold_row(input logic [ROW_BITS-1:0] r);
    logic [ROW_KEEP-1:0] f;
    f = '0;
    for (int i = 0; i < ROW_BITS; i++) f[i % ROW_KEEP] ^= r[i];
    return f;
  endfunction

  // Bank trackers
  bank_state_e         now_st  [NBANK];
  logic [ROW_BITS-1:0] bank_row[NBANK];
  bank_state_e         nst     [NBANK];
  logic [TMR_W-1:0]    nbusy   [NBANK];
  logic [NBANK-1:0]    nupd;
  logic [NBANK-1:0]    row_ld;

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      sdram_bank_tracker #(
        .ROW_BITS (ROW_BITS),
        .TMR_W    (TMR_W)
      ) i_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (nupd[g]),
        .upd_state (nst[g]),
        .upd_busy  (nbusy[g]),
        .row_load  (row_ld[g]),
        .row_in    (row_f),
        .now_state (now_st[g]),
        .row_q     (bank_row[g])
      );
    end
  endgenerate

  // Transfer engine state
  logic                 eng_on_q, eng_wr_q, eng_ap_q;
  logic [BANK_BITS-1:0] eng_bank_q;
  logic [COL_BITS-1:0]  eng_col_q;
  logic [CNT_W-1:0]     eng_cnt_q;

  logic                 cur_on, cur_wr, cur_ap;
  logic [BANK_BITS-1:0] cur_bank;
  logic [COL_BITS-1:0]  cur_col;
  logic [CNT_W-1:0]     cur_cnt;
  logic                 nxt_on;
  logic [COL_BITS-1:0]  nxt_col;
  logic [CNT_W-1:0]     nxt_cnt;
  logic                 illegal;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      nst[b]   = now_st[b];
      nbusy[b] = '0;
    end
    nupd     = '0;
    row_ld   = '0;
    illegal  = 1'b0;
    cur_on   = eng_on_q;
    cur_wr   = eng_wr_q;
    cur_ap   = eng_ap_q;
    cur_bank = eng_bank_q;
    cur_col  = eng_col_q;
    cur_cnt  = eng_cnt_q;

    // Command stage
    case (cmd_e)
      CMD_MODE, CMD_REFRESH: begin
        for (int b = 0; b < NBANK; b++)
          if (now_st[b] != BK_IDLE) illegal = 1'b1;
        if (!illegal && cmd_e == CMD_REFRESH) begin
          for (int b = 0; b < NBANK; b++) begin
            nst[b]   = BK_REFRESHING;
            nbusy[b] = TMR_W'(T_RC - 1);
          end
          nupd = '1;
        end
      end
      CMD_PRECHARGE: begin
        for (int b = 0; b < NBANK; b++)
          if ((flag10 || BANK_BITS'(b) == tgt_bank) &&
              (now_st[b] inside {BK_OPENING, BK_PRECHARGING, BK_REFRESHING}))
            illegal = 1'b1;
        if (!illegal) begin
          for (int b = 0; b < NBANK; b++) begin
            if (flag10 || BANK_BITS'(b) == tgt_bank) begin
              if (now_st[b] inside {BK_READING, BK_WRITING}) begin
                nst[b]  = BK_ACTIVE;
                nupd[b] = 1'b1;
                cur_on  = 1'b0;
              end else if (now_st[b] inside {BK_ACTIVE, BK_UNKNOWN}) begin
                nst[b]   = BK_PRECHARGING;
                nbusy[b] = TMR_W'(T_RP - 1);
                nupd[b]  = 1'b1;
              end
            end
          end
        end
      end
      CMD_ACTIVATE: begin
        if (now_st[tgt_bank] != BK_IDLE) begin
          illegal = 1'b1;
        end else begin
          nst[tgt_bank]    = BK_OPENING;
          nbusy[tgt_bank]  = TMR_W'(T_RCD - 1);
          nupd[tgt_bank]   = 1'b1;
          row_ld[tgt_bank] = 1'b1;
        end
      end
      CMD_READ, CMD_WRITE: begin
        if (!(now_st[tgt_bank] inside {BK_ACTIVE, BK_READING, BK_WRITING})) begin
          illegal = 1'b1;
        end else begin
          if (eng_on_q && eng_bank_q != tgt_bank) begin
            nst[eng_bank_q]   = eng_ap_q ? BK_PRECHARGING : BK_ACTIVE;
            nbusy[eng_bank_q] = eng_ap_q ? TMR_W'(T_RP - 1) : '0;
            nupd[eng_bank_q]  = 1'b1;
          end
          cur_on   = 1'b1;
          cur_wr   = (cmd_e == CMD_WRITE);
          cur_ap   = flag10;
          cur_bank = tgt_bank;
          cur_col  = col_f;
          cur_cnt  = CNT_W'(BURST_LEN);
          nst[tgt_bank]   = (cmd_e == CMD_WRITE) ? BK_WRITING : BK_READING;
          nbusy[tgt_bank] = '0;
          nupd[tgt_bank]  = 1'b1;
        end
      end
      CMD_STOP: begin
        if (eng_on_q) begin
          nst[eng_bank_q]   = eng_ap_q ? BK_PRECHARGING : BK_ACTIVE;
          nbusy[eng_bank_q] = eng_ap_q ? TMR_W'(T_RP - 1) : '0;
          nupd[eng_bank_q]  = 1'b1;
          cur_on            = 1'b0;
        end
      end
      default: ;
    endcase

    // Beat stage
    nxt_on  = cur_on;
    nxt_col = cur_col;
    nxt_cnt = cur_cnt;
    if (cur_on) begin
      if (cur_cnt == CNT_W'(1)) begin
        nxt_on          = 1'b0;
        nst[cur_bank]   = cur_ap ? BK_PRECHARGING : BK_ACTIVE;
        nbusy[cur_bank] = cur_ap ? TMR_W'(T_RP - 1) : '0;
        nupd[cur_bank]  = 1'b1;
      end else begin
        nxt_cnt = cur_cnt - CNT_W'(1);
        nxt_col = cur_col + COL_BITS'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_on_q   <= 1'b0;
      eng_wr_q   <= 1'b0;
      eng_ap_q   <= 1'b0;
      eng_bank_q <= '0;
      eng_col_q  <= '0;
      eng_cnt_q  <= '0;
    end else begin
      eng_on_q   <= nxt_on;
      eng_wr_q   <= cur_wr;
      eng_ap_q   <= cur_ap;
      eng_bank_q <= cur_bank;
      eng_col_q  <= nxt_col;
      eng_cnt_q  <= nxt_cnt;
    end
  end

  // Storage and read path
  logic [IDX_W-1:0]  beat_idx;
  logic [WORD_W-1:0] store_word;

  assign beat_idx = {cur_bank, fold_row(bank_row[cur_bank]), cur_col};

  sdram_word_store #(
    .IDX_W (IDX_W)
  ) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cur_on && cur_wr),
    .idx   (beat_idx),
    .wword (wdata),
    .rword (store_word)
  );

  sdram_read_pipe #(
    .DEPTH (RD_STAGES)
  ) i_rpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cur_on && !cur_wr),
    .in_word   (store_word),
    .out_valid (rdata_valid),
    .out_word  (rdata)
  );

  // Error reporting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
      err_cmd    <= '0;
    end else begin
      err_pulse <= illegal;
      if (illegal) begin
        err_sticky <= 1'b1;
        err_cmd    <= cmd;
      end
    end
  end

  logic [NBANK-1:0] rw_vec;
  always_comb
    for (int b = 0; b < NBANK; b++)
      rw_vec[b] = now_st[b] inside {BK_READING, BK_WRITING};

  // R12: sticky error never drops without reset
  a_r12_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R12: every pulse is reflected in the sticky bit
  a_r12_pulse_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  // R10: at most one bank is ever in a transfer
  a_r10_single_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rw_vec) <= 1);

  // R8: a running burst always belongs to a bank in a transfer state
  a_r8_engine_owns_bank: assert property (@(posedge clk) disable iff (!rst_n)
    eng_on_q |-> rw_vec[eng_bank_q]);

endmodule

// File: tb/test_sdram_bank_model.sv
module test_sdram_bank_model;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd;
  logic [11:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rdata_valid, err_pulse, err_sticky;
  logic [2:0]  err_cmd;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  sdram_bank_model #(
    .BURST_LEN (4)
  ) i_sdram_bank_model (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .rdata_valid (rdata_valid),
    .err_pulse   (err_pulse),
    .err_sticky  (err_sticky),
    .err_cmd     (err_cmd)
  );

  localparam logic [2:0] MOD = 3'd0, REF = 3'd1, PRE = 3'd2, ACT = 3'd3,
                         WR = 3'd4, RD = 3'd5, STP = 3'd6, NOP = 3'd7;

  // {req, cmd, addr, wdata, exp err_pulse, exp rdata_valid, exp rdata}
  // expectations are the outputs seen while this row is being driven
  localparam int NV = 40;
  localparam logic [52:0] VEC [NV] = '{
    {4'd2,  REF, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7}, // R2 refresh while unknown
    {4'd3,  PRE, 12'h400, 16'h0000, 1'b1, 1'b0, 16'hE7E7}, // R3 precharge all
    {4'd3,  ACT, 12'h001, 16'h0000, 1'b0, 1'b0, 16'hE7E7}, // R3 too early
    {4'd4,  ACT, 12'h001, 16'h0000, 1'b1, 1'b0, 16'hE7E7}, // R4 row 1
    {4'd4,  WR,  12'h005, 16'hDEAD, 1'b0, 1'b0, 16'hE7E7}, // R4 too early
    {4'd7,  WR,  12'h0FE, 16'hA000, 1'b1, 1'b0, 16'hE7E7}, // R7 burst write
    {4'd8,  NOP, 12'h000, 16'hA001, 1'b0, 1'b0, 16'hE7E7},
    {4'd8,  NOP, 12'h000, 16'hA002, 1'b0, 1'b0, 16'hE7E7}, // R8 column wrap
    {4'd8,  NOP, 12'h000, 16'hA003, 1'b0, 1'b0, 16'hE7E7},
    {4'd6,  RD,  12'h0FE, 16'h0000, 1'b0, 1'b0, 16'hE7E7}, // R6 burst read
    {4'd6,  NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd6,  NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd6,  NOP, 12'h000, 16'h0000, 1'b0, 1'b1, 16'hA000},
    {4'd8,  NOP, 12'h000, 16'h0000, 1'b0, 1'b1, 16'hA001},
    {4'd8,  NOP, 12'h000, 16'h0000, 1'b0, 1'b1, 16'hA002},
    {4'd8,  NOP, 12'h000, 16'h0000, 1'b0, 1'b1, 16'hA003},
    {4'd11, RD,  12'h410, 16'h0000, 1'b0, 1'b0, 16'hE7E7}, // R11 read with auto-precharge
    {4'd11, STP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7}, // R11 stop after one beat
    {4'd9,  ACT, 12'h002, 16'h0000, 1'b0, 1'b0, 16'hE7E7}, // R9 still precharging
    {4'd9,  ACT, 12'h003, 16'h0000, 1'b1, 1'b1, 16'hFEFE}, // R9 idle again
    {4'd11, NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd7,  WR,  12'h020, 16'hB000, 1'b0, 1'b0, 16'hE7E7},
    {4'd10, RD,  12'h020, 16'hBBBB, 1'b0, 1'b0, 16'hE7E7}, // R10 cuts the write
    {4'd10, NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd10, NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd10, NOP, 12'h000, 16'h0000, 1'b0, 1'b1, 16'hB000},
    {4'd10, NOP, 12'h000, 16'h0000, 1'b0, 1'b1, 16'hFEFE},
    {4'd10, NOP, 12'h000, 16'h0000, 1'b0, 1'b1, 16'hFEFE},
    {4'd3,  PRE, 12'h000, 16'h0000, 1'b0, 1'b1, 16'hFEFE}, // R3 bank 0 only
    {4'd2,  MOD, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7}, // R2 bank busy
    {4'd2,  MOD, 12'h000, 16'h0000, 1'b1, 1'b0, 16'hE7E7},
    {4'd2,  REF, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd2,  ACT, 12'h800, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd2,  NOP, 12'h000, 16'h0000, 1'b1, 1'b0, 16'hE7E7},
    {4'd2,  NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd2,  NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd2,  NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7},
    {4'd2,  ACT, 12'h800, 16'h0000, 1'b0, 1'b0, 16'hE7E7}, // R2 one short of T_RC-1
    {4'd2,  ACT, 12'h800, 16'h0000, 1'b1, 1'b0, 16'hE7E7},
    {4'd2,  NOP, 12'h000, 16'h0000, 1'b0, 1'b0, 16'hE7E7}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [11:0] a, input logic [15:0] w);
    cmd = c; addr = a; wdata = w;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd = NOP; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 rdata", 32'(rdata), 32'hE7E7);
    check("R1 rdata_valid", 32'(rdata_valid), 32'd0);
    check("R1 err_pulse", 32'(err_pulse), 32'd0);
    check("R1 err_sticky", 32'(err_sticky), 32'd0);

    for (int i = 0; i < NV; i++) begin
      n_checks++;
      if ({err_pulse, rdata_valid, rdata} !== VEC[i][17:0]) begin
        n_fails++;
        $display("FAIL R%0d row %0d actual=%h expected=%h", VEC[i][52:49], i,
                 {err_pulse, rdata_valid, rdata}, VEC[i][17:0]);
      end
      cmd = VEC[i][48:46]; addr = VEC[i][45:34]; wdata = VEC[i][33:18];
      @(negedge clk);
    end

    // R12 last illegal command was an activate
    check("R12 err_sticky", 32'(err_sticky), 32'd1);
    check("R12 err_cmd", 32'(err_cmd), 32'd3);
    check("R12 pulse low", 32'(err_pulse), 32'd0);

    // R5 read on an idle bank
    step(RD, 12'h000, 16'h0);
    check("R5 err_pulse", 32'(err_pulse), 32'd1);
    check("R5 err_cmd", 32'(err_cmd), 32'd5);
    cmd = NOP;

    // R1 reset again, storage refilled
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 sticky cleared", 32'(err_sticky), 32'd0);
    check("R1 marker", 32'(rdata), 32'hE7E7);
    step(PRE, 12'h400, 16'h0);
    step(NOP, 12'h000, 16'h0);
    step(ACT, 12'h001, 16'h0);
    check("R1 activate legal", 32'(err_pulse), 32'd0);
    step(NOP, 12'h000, 16'h0);
    step(RD, 12'h0FE, 16'h0);
    step(NOP, 12'h000, 16'h0);
    step(NOP, 12'h000, 16'h0);
    check("R1 fill word valid", 32'(rdata_valid), 32'd1);
    check("R1 fill word", 32'(rdata), 32'hFEFE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule